// File: doc/BRIEF.md
# Banked Private Peripheral Address Decoder

This block sits in front of the private register space of a processor cluster of up to four cores. It takes one access per cycle: a 12-bit offset, read and write strobes, write data and the index of the core that issued the access. It then routes the access to one of three targets. The first is a small snoop-control register set that lives inside this block. The second is the per-core interrupt CPU interface. The third is the per-core timer/watchdog pair. The interrupt interfaces and the timers sit outside the block, and each hands back its read word on a flattened read bus.

Each per-core resource can be reached in two ways. A "self" page always resolves to the copy owned by the core that issued the access. A set of numbered pages, one per core, names the target core through the address. For each target the block drives a one-hot select, a local sub-offset and the forwarded write data. It returns a registered read word one cycle after a read. Offsets that map to nothing raise a one-cycle error pulse, and reads of those offsets return zero. The parameter `NUM_CORES` (1 to 4) sets how many cores are present. Numbered pages that belong to absent cores count as unmapped.

Top module: `ppd_private_decoder`

## Requirements
- R1: After reset the control flag reads 0, `acc_rdata` is 0 and `acc_err` is 0.
- R2: Offsets 0x000–0x0FF assert `scu_sel`. The control register at sub-offset 0x00 stores only write-data bit 0 and returns it in bit 0, with every other bit zero.
- R3: In the control page, sub-offset 0x04 reads NUM_CORES−1 in bits [1:0] and a present-core mask in bits [7:4] (bit 4+i set for core i). Sub-offset 0x08 (core status) reads 0. A write to sub-offset 0x0C (invalidate-all) is accepted, changes no state and reads back 0.
- R4: Offsets 0x100–0x1FF select the interrupt interface of `req_core`, with `tgt_sub` = offset[7:0].
- R5: Offsets 0x200–0x5FF select the interrupt interface of core (offset−0x200)>>8, with `tgt_sub` = offset[7:0].
- R6: Offsets 0x600–0x6FF select timer instance 2·`req_core`+offset[5] (bit 5 = 1 is the watchdog), with `tgt_sub` = {4'b0, offset[3:0]}.
- R7: Offsets 0x700–0xAFF select timer instance 2·core+offset[5], where core = (offset−0x700)>>8, with `tgt_sub` = {4'b0, offset[3:0]}.
- R8: Offsets 0xB00 and above assert no select. The cycle after such an access `acc_err` is high for exactly one cycle and `acc_rdata` is 0.
- R9: A numbered page whose core index is NUM_CORES or more behaves like R8: no select, a one-cycle error pulse and zero read data.
- R10: `acc_rdata` shows, in the cycle after a read, the word of the target selected by that read. In any cycle that does not follow a read it is 0.
- R11: At most one select is high at any time, and none is high while both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_off | input | 12 | Offset of the access within the private region |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | DATA_W | Write data |
| req_core | input | 2 | Index of the core issuing the access |
| gic_rdata | input | NUM_CORES*DATA_W | Read words of the interrupt interfaces, core 0 in the low slice |
| tmr_rdata | input | 2*NUM_CORES*DATA_W | Read words of the timer instances, instance 0 in the low slice |
| scu_sel | output | 1 | Control register set selected |
| gic_sel | output | NUM_CORES | One-hot select of an interrupt interface |
| tmr_sel | output | 2*NUM_CORES | One-hot select of a timer instance |
| tgt_sub | output | 8 | Local sub-offset passed to the selected target |
| tgt_wdata | output | DATA_W | Write data forwarded to the targets |
| acc_rdata | output | DATA_W | Registered read word |
| acc_err | output | 1 | One-cycle pulse after an access to an unmapped offset |

## Verification
The bench builds the decoder with `NUM_CORES` = 3 and `DATA_W` = 32. With three cores, the fourth numbered page of each window names an absent core, so the out-of-range error path of R9 can be reached as well as the top-of-map error of R8. The configuration word has a partial core mask (0x72) that could not be confused with the full-cluster value. Each interrupt interface and timer instance returns a distinct stub word, so a wrong core or a timer/watchdog swap shows up directly in the returned data.

// File: rtl/ppd_pkg.sv
// Shared constants and types for the private peripheral decoder.
// Assumes a fixed 4 KB map split into 256-byte pages.
package ppd_pkg;

    localparam int OFF_W     = 12;
    localparam int PAGE_W    = 4;
    localparam int SUB_W     = 8;
    localparam int CORE_W    = 2;
    localparam int MAX_CORES = 4;

    // Page numbers (offset[11:8]) that bound each window.
    localparam logic [PAGE_W-1:0] PG_CTRL      = 4'd0;
    localparam logic [PAGE_W-1:0] PG_IRQ_SELF  = 4'd1;
    localparam logic [PAGE_W-1:0] PG_IRQ_BASE  = 4'd2;
    localparam logic [PAGE_W-1:0] PG_TMR_SELF  = 4'd6;
    localparam logic [PAGE_W-1:0] PG_TMR_BASE  = 4'd7;
    localparam logic [PAGE_W-1:0] PG_MAP_END   = 4'd11;

    // Control register sub-offsets.
    localparam logic [SUB_W-1:0] SUB_CTRL  = 8'h00;
    localparam logic [SUB_W-1:0] SUB_CFG   = 8'h04;
    localparam logic [SUB_W-1:0] SUB_STAT  = 8'h08;
    localparam logic [SUB_W-1:0] SUB_INVAL = 8'h0C;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_IRQ  = 2'd2,
        TGT_TMR  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [CORE_W-1:0] core;
        logic              wdog;
        logic [SUB_W-1:0]  sub;
    } route_t;

endpackage

// File: rtl/ppd_window_decode.sv
// Combinational window decoder: turns an offset and the requesting core into
// a route (target kind, core, timer/watchdog, sub-offset) plus an unmapped flag.
// Assumes req_core < NUM_CORES; numbered pages of absent cores are unmapped.
module ppd_window_decode
    import ppd_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [CORE_W-1:0] req_core,
    output route_t            route,
    output logic              bad
);

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] rel;

    assign page = off[OFF_W-1:SUB_W];

    // Classify the page and derive target core and sub-offset.
    always_comb begin
        route = '{tgt: TGT_NONE, core: '0, wdog: 1'b0, sub: '0};
        rel   = '0;
        bad   = 1'b0;
        if (page == PG_CTRL) begin
            route.tgt = TGT_CTRL;
            route.sub = off[SUB_W-1:0];
        end else if (page == PG_IRQ_SELF) begin
            route.tgt  = TGT_IRQ;
            route.core = req_core;
            route.sub  = off[SUB_W-1:0];
        end else if (page < PG_TMR_SELF) begin
            rel        = page - PG_IRQ_BASE;
            route.tgt  = TGT_IRQ;
            route.core = rel[CORE_W-1:0];
            route.sub  = off[SUB_W-1:0];
            bad        = int'(rel) >= NUM_CORES;
        end else if (page == PG_TMR_SELF) begin
            route.tgt  = TGT_TMR;
            route.core = req_core;
            route.wdog = off[5];
            route.sub  = {4'b0, off[3:0]};
        end else if (page < PG_MAP_END) begin
            rel        = page - PG_TMR_BASE;
            route.tgt  = TGT_TMR;
            route.core = rel[CORE_W-1:0];
            route.wdog = off[5];
            route.sub  = {4'b0, off[3:0]};
            bad        = int'(rel) >= NUM_CORES;
        end else begin
            bad = 1'b1;
        end
        if (bad) begin
            route.tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/ppd_ctrl_regs.sv
// Snoop-control register set: one writable enable flag, a read-only
// configuration word built from NUM_CORES, a zero core-status word and a
// write-only invalidate register with no effect. Assumes DATA_W >= 8.
module ppd_ctrl_regs
    import ppd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              wbit,
    input  logic [SUB_W-1:0]  sub,
    output logic [DATA_W-1:0] rdata
);

    logic              ctrl_en;
    logic [DATA_W-1:0] cfg_word;

    // Hold the enable flag; only the control sub-offset updates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
        end else if (sel && wr_en && sub == SUB_CTRL) begin
            ctrl_en <= wbit;
        end
    end

    // Build the configuration word: core count minus one and a presence mask.
    always_comb begin
        cfg_word      = '0;
        cfg_word[1:0] = 2'(NUM_CORES - 1);
        for (int i = 0; i < NUM_CORES; i++) begin
            cfg_word[4+i] = 1'b1;
        end
    end

    // Read multiplexer for the register set.
    always_comb begin
        rdata = '0;
        case (sub)
            SUB_CTRL: rdata[0] = ctrl_en;
            SUB_CFG:  rdata    = cfg_word;
            SUB_STAT, SUB_INVAL: rdata = '0;
            default:  rdata    = '0;
        endcase
    end

endmodule

// File: rtl/ppd_read_return.sv
// Read-return stage: picks the word of the routed target and registers it,
// and registers the one-cycle error pulse for unmapped accesses.
// Assumes the targets return read data combinationally in the access cycle.
module ppd_read_return
    import ppd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    localparam int NUM_TMR  = 2 * NUM_CORES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic                        acc,
    input  route_t                      route,
    input  logic                        bad,
    input  logic [DATA_W-1:0]           ctrl_rdata,
    input  logic [NUM_CORES*DATA_W-1:0] irq_rdata,
    input  logic [NUM_TMR*DATA_W-1:0]   tmr_rdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        err
);

    logic [DATA_W-1:0] pick;

    // Select the word of the routed target.
    always_comb begin
        pick = '0;
        case (route.tgt)
            TGT_CTRL: pick = ctrl_rdata;
            TGT_IRQ: begin
                for (int i = 0; i < NUM_CORES; i++) begin
                    if (route.core == CORE_W'(i)) begin
                        pick = irq_rdata[i*DATA_W +: DATA_W];
                    end
                end
            end
            TGT_TMR: begin
                for (int j = 0; j < NUM_TMR; j++) begin
                    if ({route.core, route.wdog} == (CORE_W+1)'(j)) begin
                        pick = tmr_rdata[j*DATA_W +: DATA_W];
                    end
                end
            end
            default: pick = '0;
        endcase
    end

    // Register returned data and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= (rd_en && !bad) ? pick : '0;
            err   <= acc && bad;
        end
    end

endmodule

// File: rtl/ppd_private_decoder.sv
// Top of the banked private peripheral decoder. Decodes one access per
// cycle into one-hot target selects, forwards the sub-offset and write data,
// and returns a registered read word and error pulse one cycle later.
// Assumes req_core < NUM_CORES and NUM_CORES in 1..4.
module ppd_private_decoder
    import ppd_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    localparam int NUM_TMR  = 2 * NUM_CORES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [11:0]                 acc_off,
    input  logic                        acc_rd,
    input  logic                        acc_wr,
    input  logic [DATA_W-1:0]           acc_wdata,
    input  logic [1:0]                  req_core,
    input  logic [NUM_CORES*DATA_W-1:0] gic_rdata,
    input  logic [NUM_TMR*DATA_W-1:0]   tmr_rdata,
    output logic                        scu_sel,
    output logic [NUM_CORES-1:0]        gic_sel,
    output logic [NUM_TMR-1:0]          tmr_sel,
    output logic [7:0]                  tgt_sub,
    output logic [DATA_W-1:0]           tgt_wdata,
    output logic [DATA_W-1:0]           acc_rdata,
    output logic                        acc_err
);

    logic              acc;
    route_t            route;
    logic              bad;
    logic [DATA_W-1:0] ctrl_rdata;

    assign acc       = acc_rd | acc_wr;
    assign tgt_sub   = route.sub;
    assign tgt_wdata = acc_wdata;
    assign scu_sel   = acc && route.tgt == TGT_CTRL;

    ppd_window_decode #(
        .NUM_CORES(NUM_CORES)
    ) u_decode (
        .off      (acc_off),
        .req_core (req_core),
        .route    (route),
        .bad      (bad)
    );

    ppd_ctrl_regs #(
        .NUM_CORES(NUM_CORES),
        .DATA_W   (DATA_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (scu_sel),
        .wr_en (acc_wr),
        .wbit  (acc_wdata[0]),
        .sub   (route.sub),
        .rdata (ctrl_rdata)
    );

    // One select per interrupt interface.
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_irq_sel
        assign gic_sel[gi] = acc && route.tgt == TGT_IRQ
                             && route.core == CORE_W'(gi);
    end

    // One select per timer instance (core*2 + watchdog bit).
    for (genvar gt = 0; gt < NUM_TMR; gt++) begin : g_tmr_sel
        assign tmr_sel[gt] = acc && route.tgt == TGT_TMR
                             && {route.core, route.wdog} == (CORE_W+1)'(gt);
    end

    ppd_read_return #(
        .NUM_CORES(NUM_CORES),
        .DATA_W   (DATA_W)
    ) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (acc_rd),
        .acc        (acc),
        .route      (route),
        .bad        (bad),
        .ctrl_rdata (ctrl_rdata),
        .irq_rdata  (gic_rdata),
        .tmr_rdata  (tmr_rdata),
        .rdata      (acc_rdata),
        .err        (acc_err)
    );

endmodule

// File: rtl/ppd_private_decoder_chk.sv
// Property checker for the private decoder, attached by bind below.
// Observes ports only.
module ppd_private_decoder_chk #(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    localparam int NUM_TMR  = 2 * NUM_CORES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [11:0]          acc_off,
    input logic                 acc_rd,
    input logic                 acc_wr,
    input logic [1:0]           req_core,
    input logic                 scu_sel,
    input logic [NUM_CORES-1:0] gic_sel,
    input logic [NUM_TMR-1:0]   tmr_sel,
    input logic [DATA_W-1:0]    acc_rdata,
    input logic                 acc_err
);

    logic acc;
    assign acc = acc_rd | acc_wr;

    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scu_sel, gic_sel, tmr_sel}));

    p_idle_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> ({scu_sel, gic_sel, tmr_sel} == '0));

    p_ctrl_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_off[11:8] == 4'h0) |-> scu_sel);

    p_self_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_off[11:8] == 4'h1 && int'(req_core) < NUM_CORES)
        |-> (gic_sel == (NUM_CORES'(1) << req_core)));

    p_top_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && acc_off >= 12'hB00) |=> acc_err);

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (acc_rdata == '0));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc));

endmodule

bind ppd_private_decoder ppd_private_decoder_chk #(
    .NUM_CORES(NUM_CORES),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_off   (acc_off),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .req_core  (req_core),
    .scu_sel   (scu_sel),
    .gic_sel   (gic_sel),
    .tmr_sel   (tmr_sel),
    .acc_rdata (acc_rdata),
    .acc_err   (acc_err)
);

// File: tb/ppd_private_decoder_test.sv
`timescale 1ns/1ps
// Directed bench for the private decoder, built with three cores.
module ppd_private_decoder_test;

    localparam int NC = 3;
    localparam int DW = 32;
    localparam int NT = 2 * NC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      acc_off = '0;
    logic             acc_rd = 1'b0;
    logic             acc_wr = 1'b0;
    logic [DW-1:0]    acc_wdata = '0;
    logic [1:0]       req_core = '0;
    logic [NC*DW-1:0] gic_rdata;
    logic [NT*DW-1:0] tmr_rdata;
    logic             scu_sel;
    logic [NC-1:0]    gic_sel;
    logic [NT-1:0]    tmr_sel;
    logic [7:0]       tgt_sub;
    logic [DW-1:0]    tgt_wdata;
    logic [DW-1:0]    acc_rdata;
    logic             acc_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Captured results of the last access.
    logic          c_scu;
    logic [NC-1:0] c_gic;
    logic [NT-1:0] c_tmr;
    logic [7:0]    c_sub;
    logic [DW-1:0] c_rdata;
    logic          c_err;

    always #2.5 clk = ~clk;

    ppd_private_decoder #(.NUM_CORES(NC), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_wdata(acc_wdata), .req_core(req_core),
        .gic_rdata(gic_rdata), .tmr_rdata(tmr_rdata), .scu_sel(scu_sel),
        .gic_sel(gic_sel), .tmr_sel(tmr_sel), .tgt_sub(tgt_sub),
        .tgt_wdata(tgt_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    function automatic logic [DW-1:0] irq_word(int c);
        return 32'h6100_0000 | c;
    endfunction

    function automatic logic [DW-1:0] tmr_word(int j);
        return 32'h7200_0000 | j;
    endfunction

    // Stub target read words.
    initial begin
        for (int i = 0; i < NC; i++) gic_rdata[i*DW +: DW] = irq_word(i);
        for (int j = 0; j < NT; j++) tmr_rdata[j*DW +: DW] = tmr_word(j);
    end

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at negedge, capture selects, then registered results.
    task automatic access(logic [11:0] off, logic rd, logic wr,
                          logic [DW-1:0] wd, logic [1:0] core);
        @(negedge clk);
        acc_off = off; acc_rd = rd; acc_wr = wr; acc_wdata = wd; req_core = core;
        #1;
        c_scu = scu_sel; c_gic = gic_sel; c_tmr = tmr_sel; c_sub = tgt_sub;
        @(posedge clk);
        #1;
        c_rdata = acc_rdata; c_err = acc_err;
        acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rdata", acc_rdata, '0);
        check("R1 err", 32'(acc_err), 0);
        access(12'h000, 1'b1, 1'b0, '0, 2'd0);
        check("R1 ctrl", c_rdata, '0);
    endtask

    task automatic t_ctrl;
        access(12'h000, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd1);
        check("R2 sel", 32'(c_scu), 1);
        access(12'h000, 1'b1, 1'b0, '0, 2'd1);
        check("R2 ctrl one", c_rdata, 32'h1);
        access(12'h000, 1'b0, 1'b1, 32'hFFFF_FFFE, 2'd0);
        access(12'h000, 1'b1, 1'b0, '0, 2'd0);
        check("R2 ctrl zero", c_rdata, 32'h0);
        access(12'h004, 1'b1, 1'b0, '0, 2'd2);
        check("R3 config", c_rdata, 32'h72);
        access(12'h008, 1'b1, 1'b0, '0, 2'd2);
        check("R3 status", c_rdata, 32'h0);
        access(12'h000, 1'b0, 1'b1, 32'h1, 2'd0);
        access(12'h00C, 1'b0, 1'b1, 32'hFFFF_FFFE, 2'd0);
        check("R3 inval err", 32'(c_err), 0);
        access(12'h000, 1'b1, 1'b0, '0, 2'd0);
        check("R3 inval no effect", c_rdata, 32'h1);
        access(12'h00C, 1'b1, 1'b0, '0, 2'd0);
        check("R3 inval reads zero", c_rdata, 32'h0);
    endtask

    task automatic t_irq_self;
        for (int c = 0; c < NC; c++) begin
            access(12'h1A4, 1'b1, 1'b0, '0, 2'(c));
            check("R4 sel", 32'(c_gic), 32'(1 << c));
            check("R4 sub", 32'(c_sub), 32'hA4);
            check("R10 irq data", c_rdata, irq_word(c));
        end
    endtask

    task automatic t_irq_numbered;
        for (int c = 0; c < NC; c++) begin
            access(12'(32'h200 + c * 32'h100 + 32'h3C), 1'b1, 1'b0, '0, 2'((c + 1) % NC));
            check("R5 sel", 32'(c_gic), 32'(1 << c));
            check("R5 sub", 32'(c_sub), 32'h3C);
            check("R5 data", c_rdata, irq_word(c));
        end
        access(12'h510, 1'b1, 1'b0, '0, 2'd0);
        check("R9 irq absent sel", 32'({c_scu, c_gic, c_tmr}), 0);
        check("R9 irq absent err", 32'(c_err), 1);
        check("R9 irq absent data", c_rdata, '0);
    endtask

    task automatic t_tmr_self;
        access(12'h628, 1'b1, 1'b0, '0, 2'd1);
        check("R6 wdog sel", 32'(c_tmr), 32'(1 << 3));
        check("R6 sub", 32'(c_sub), 32'h08);
        check("R6 data", c_rdata, tmr_word(3));
        access(12'h60C, 1'b1, 1'b0, '0, 2'd2);
        check("R6 timer sel", 32'(c_tmr), 32'(1 << 4));
        check("R6 sub2", 32'(c_sub), 32'h0C);
    endtask

    task automatic t_tmr_numbered;
        access(12'h714, 1'b1, 1'b0, '0, 2'd2);
        check("R7 core0 timer", 32'(c_tmr), 32'(1 << 0));
        check("R7 sub", 32'(c_sub), 32'h04);
        access(12'h824, 1'b1, 1'b0, '0, 2'd0);
        check("R7 core1 wdog", 32'(c_tmr), 32'(1 << 3));
        check("R7 data", c_rdata, tmr_word(3));
        access(12'h93C, 1'b0, 1'b1, 32'h55, 2'd0);
        check("R7 core2 wdog", 32'(c_tmr), 32'(1 << 5));
        check("R7 wdata fwd", tgt_wdata, 32'h55);
        check("R10 write no data", c_rdata, '0);
        access(12'hA00, 1'b1, 1'b0, '0, 2'd0);
        check("R9 tmr absent sel", 32'(c_tmr), 0);
        check("R9 tmr absent err", 32'(c_err), 1);
    endtask

    task automatic t_top;
        access(12'hB00, 1'b1, 1'b0, '0, 2'd0);
        check("R8 sel", 32'({c_scu, c_gic, c_tmr}), 0);
        check("R8 err", 32'(c_err), 1);
        check("R8 data", c_rdata, '0);
        @(posedge clk); #1;
        check("R8 pulse ends", 32'(acc_err), 0);
        access(12'hFFC, 1'b0, 1'b1, 32'h1234, 2'd1);
        check("R8 write err", 32'(c_err), 1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        acc_off = 12'h200; req_core = 2'd0; acc_rd = 1'b0; acc_wr = 1'b0;
        #1;
        check("R11 idle sel", 32'({scu_sel, gic_sel, tmr_sel}), 0);
        @(posedge clk); #1;
        check("R10 idle data", acc_rdata, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_irq_self();
        t_irq_numbered();
        t_tmr_self();
        t_tmr_numbered();
        t_top();
        t_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule